// File: doc/BRIEF.md
# GCR Read Sync Detector and Byte Framer

This block sits behind the read channel of a floppy drive. It splits a fixed reference clock down to one of four bit-cell rates and samples the recovered serial data once per cell. When it sees a long run of one bits, it reports a sync mark. The first zero after that run is taken as the most significant bit of a fresh byte. From that point the block packs each group of eight cells into a byte.

When a byte is complete, the block loads it into an output latch and pulls an active-low ready strobe down for the host processor. In pulse mode the strobe is a short pulse of half a bit cell. In handshake mode the strobe stays low until the host touches the controller. A host access to the data port releases the strobe and clears the latch. An access to any other register of the controller only releases the strobe.

The cell strobe is brought out so that the read channel can see when the block samples. Data separation, writing and GCR decoding are done elsewhere.

Top module: `gcr_rd_framer`

## Requirements
- R1: `sync_n_o` goes low on the cell edge that samples the tenth consecutive one bit. The run includes ones at the end of the preceding data. After only nine ones, `sync_n_o` is still high.
- R2: Once low, `sync_n_o` stays low for any number of further one bits. It returns high on the cell edge that samples the first zero.
- R3: The first zero after a sync run is bit 7 of the next byte. Bytes are assembled most significant bit first, eight cells per byte, with no gap between bytes.
- R4: With the default `QCYC` = 4, zone 00, 01, 10 and 11 give cell periods of 64, 60, 56 and 52 reference cycles. `cell_stb_o` is high for one cycle per cell. The cell counter reloads when the zone changes.
- R5: On the edge that samples a byte's eighth bit, `brdy_n_o` falls and `byte_o` takes the new byte.
- R6: With `hs_mode_i` = 0, `brdy_n_o` stays low for half a cell period: 32, 30, 28 or 26 cycles for zones 00 to 11.
- R7: With `hs_mode_i` = 1, `brdy_n_o` stays low until a host access.
- R8: A one-cycle `acc_i` with `acc_data_i` = 1 (data port) sets `brdy_n_o` high and `byte_o` to 0x00. With `acc_data_i` = 0 (another register), it sets `brdy_n_o` high and leaves `byte_o` unchanged. A byte completing in the same cycle takes priority.
- R9: While a sync run is active, no byte completes and `brdy_n_o` does not fall.
- R10: During reset, `sync_n_o` = 1, `brdy_n_o` = 1 and `byte_o` = 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| zone_i | input | 2 | Bit-rate zone select |
| data_i | input | 1 | Recovered serial read data |
| hs_mode_i | input | 1 | 1 = handshake ready, 0 = pulse ready |
| acc_i | input | 1 | Host access strobe, one cycle |
| acc_data_i | input | 1 | 1 = access targets the data port |
| cell_stb_o | output | 1 | One-cycle strobe at each bit-cell sample point |
| sync_n_o | output | 1 | Sync detected, active low |
| brdy_n_o | output | 1 | Byte ready, active low |
| byte_o | output | 8 | Latched byte |

## Verification
The assertions assume three things about the inputs. `data_i` is only meaningful on cycles where `cell_stb_o` is high. `acc_i` is a single-cycle strobe. The zone only changes between cells.

The access checks leave out cycles where a cell strobe falls together with an access, because a completing byte wins there. The bench keeps to these assumptions. It changes `data_i` only on the falling clock edge after the sampling edge. It issues host accesses while the stream sits inside a sync run, so no byte can complete on the same edge. It switches zones only after a cell has been consumed.

// File: rtl/gcr_rd_pkg.sv
package gcr_rd_pkg;
  typedef logic [1:0] zone_t;

  // cell length in reference cycles; qcyc = reference cycles per 0.25 us
  function automatic int unsigned cell_cycles(int unsigned qcyc, zone_t z);
    return qcyc * (16 - int'(z));
  endfunction
endpackage

// File: rtl/gcr_cell_timer.sv
module gcr_cell_timer
  import gcr_rd_pkg::*;
#(
  parameter int unsigned QCYC = 4,
  parameter int unsigned CW   = $clog2(QCYC * 16 + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  zone_t         zone_i,
  output logic          stb_o,
  output logic [CW-1:0] half_o
);
  zone_t         zone_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      zone_q <= '0;
      cnt_q  <= CW'(cell_cycles(QCYC, 2'd0) - 1);
    end else if (zone_i != zone_q) begin
      zone_q <= zone_i;
      cnt_q  <= CW'(cell_cycles(QCYC, zone_i) - 1);
    end else if (cnt_q == '0) begin
      cnt_q  <= CW'(cell_cycles(QCYC, zone_q) - 1);
    end else begin
      cnt_q  <= cnt_q - 1'b1;
    end
  end

  assign stb_o  = (cnt_q == '0) && (zone_i == zone_q);
  assign half_o = CW'(cell_cycles(QCYC, zone_q) >> 1);
endmodule

// File: rtl/gcr_sync_framer.sv
module gcr_sync_framer #(
  parameter int unsigned RUN = 10,
  parameter int unsigned OW  = $clog2(RUN + 1)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       stb_i,
  input  logic       data_i,
  output logic       sync_o,
  output logic       done_o,
  output logic [7:0] byte_o
);
  logic [OW-1:0] ones_q;
  logic          sync_q;
  logic [2:0]    bcnt_q;
  logic [6:0]    sh_q;
  logic          hit;

  assign hit = data_i && (ones_q >= OW'(RUN - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ones_q <= '0;
      sync_q <= 1'b0;
      bcnt_q <= '0;
      sh_q   <= '0;
    end else if (stb_i) begin
      if (!data_i)                   ones_q <= '0;
      else if (ones_q != OW'(RUN))   ones_q <= ones_q + 1'b1;

      if (hit) begin
        sync_q <= 1'b1;
        bcnt_q <= '0;               // counter parked inside sync
      end else if (sync_q) begin
        sync_q <= 1'b0;             // this zero opens a new byte
        sh_q   <= {sh_q[5:0], 1'b0};
        bcnt_q <= 3'd1;
      end else begin
        sh_q   <= {sh_q[5:0], data_i};
        bcnt_q <= bcnt_q + 1'b1;
      end
    end
  end

  assign sync_o = sync_q;
  assign done_o = stb_i && !hit && !sync_q && (bcnt_q == 3'd7);
  assign byte_o = {sh_q, data_i};
endmodule

// File: rtl/gcr_byte_port.sv
module gcr_byte_port #(
  parameter int unsigned CW = 7
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          done_i,
  input  logic [7:0]    byte_i,
  input  logic [CW-1:0] half_i,
  input  logic          hs_mode_i,
  input  logic          acc_i,
  input  logic          acc_data_i,
  output logic          rdy_o,
  output logic [7:0]    latch_o
);
  logic          rdy_q;
  logic [7:0]    latch_q;
  logic [CW-1:0] pcnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdy_q   <= 1'b0;
      latch_q <= '0;
      pcnt_q  <= '0;
    end else if (done_i) begin
      rdy_q   <= 1'b1;
      latch_q <= byte_i;
      pcnt_q  <= half_i - 1'b1;
    end else if (acc_i) begin
      rdy_q   <= 1'b0;
      if (acc_data_i) latch_q <= '0;
    end else if (rdy_q && !hs_mode_i) begin
      if (pcnt_q == '0) rdy_q  <= 1'b0;
      else              pcnt_q <= pcnt_q - 1'b1;
    end
  end

  assign rdy_o   = rdy_q;
  assign latch_o = latch_q;
endmodule

// File: rtl/gcr_rd_framer.sv
module gcr_rd_framer
  import gcr_rd_pkg::*;
#(
  parameter int unsigned QCYC     = 4,
  parameter int unsigned SYNC_RUN = 10
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] zone_i,
  input  logic       data_i,
  input  logic       hs_mode_i,
  input  logic       acc_i,
  input  logic       acc_data_i,
  output logic       cell_stb_o,
  output logic       sync_n_o,
  output logic       brdy_n_o,
  output logic [7:0] byte_o
);
  localparam int unsigned CW = $clog2(QCYC * 16 + 1);

  logic          stb;
  logic [CW-1:0] half;
  logic          sync;
  logic          done;
  logic [7:0]    asm_byte;
  logic          rdy;

  gcr_cell_timer #(.QCYC(QCYC), .CW(CW)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .zone_i (zone_t'(zone_i)),
    .stb_o  (stb),
    .half_o (half)
  );

  gcr_sync_framer #(.RUN(SYNC_RUN)) u_framer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .stb_i  (stb),
    .data_i (data_i),
    .sync_o (sync),
    .done_o (done),
    .byte_o (asm_byte)
  );

  gcr_byte_port #(.CW(CW)) u_port (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .done_i     (done),
    .byte_i     (asm_byte),
    .half_i     (half),
    .hs_mode_i  (hs_mode_i),
    .acc_i      (acc_i),
    .acc_data_i (acc_data_i),
    .rdy_o      (rdy),
    .latch_o    (byte_o)
  );

  assign cell_stb_o = stb;
  assign sync_n_o   = ~sync;
  assign brdy_n_o   = ~rdy;
endmodule

// File: rtl/gcr_rd_framer_chk.sv
module gcr_rd_framer_chk #(
  parameter int unsigned RUN = 10
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       data_i,
  input logic       hs_mode_i,
  input logic       acc_i,
  input logic       acc_data_i,
  input logic       cell_stb_o,
  input logic       sync_n_o,
  input logic       brdy_n_o,
  input logic [7:0] byte_o
);
  int unsigned run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         run_q <= 0;
    else if (cell_stb_o) run_q <= data_i ? ((run_q < RUN) ? run_q + 1 : run_q) : 0;
  end

  a_r1_sync_after_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sync_n_o) |-> run_q >= RUN);

  a_r2_sync_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sync_n_o && cell_stb_o && !data_i) |=> sync_n_o);

  a_r2_sync_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sync_n_o && !(cell_stb_o && !data_i)) |=> !sync_n_o);

  a_r4_stb_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cell_stb_o |=> !cell_stb_o);

  a_r5_ready_on_cell: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(brdy_n_o) |-> $past(cell_stb_o));

  a_r9_no_ready_in_sync: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(brdy_n_o) |-> (sync_n_o && $past(sync_n_o)));

  a_r7_hs_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hs_mode_i && !brdy_n_o && !acc_i) |=> !brdy_n_o);

  a_r8_data_access: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_i && acc_data_i && !cell_stb_o) |=> (brdy_n_o && byte_o == 8'h00));

  a_r8_other_access: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_i && !acc_data_i && !cell_stb_o) |=> (brdy_n_o && $stable(byte_o)));
endmodule

bind gcr_rd_framer gcr_rd_framer_chk #(.RUN(SYNC_RUN)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .data_i     (data_i),
  .hs_mode_i  (hs_mode_i),
  .acc_i      (acc_i),
  .acc_data_i (acc_data_i),
  .cell_stb_o (cell_stb_o),
  .sync_n_o   (sync_n_o),
  .brdy_n_o   (brdy_n_o),
  .byte_o     (byte_o)
);

// File: tb/gcr_rd_framer_tb.sv
module gcr_rd_framer_tb;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] zone_i = 2'd0;
  logic       data_i = 1'b1;
  logic       hs_mode_i = 1'b0;
  logic       acc_i = 1'b0;
  logic       acc_data_i = 1'b0;
  logic       cell_stb_o, sync_n_o, brdy_n_o;
  logic [7:0] byte_o;

  always #10 clk = ~clk;

  gcr_rd_framer u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .zone_i(zone_i), .data_i(data_i),
    .hs_mode_i(hs_mode_i), .acc_i(acc_i), .acc_data_i(acc_data_i),
    .cell_stb_o(cell_stb_o), .sync_n_o(sync_n_o), .brdy_n_o(brdy_n_o),
    .byte_o(byte_o)
  );

  int checks = 0, failures = 0;
  bit done = 0;
  logic [7:0] exp_q[$];

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // reference stream model, built from R1 R2 R3 R9
  int m_run = 0, m_bc = 0;
  bit m_sync = 0;
  logic [7:0] m_sh = '0;

  task automatic send_bit(bit b);
    data_i = b;
    do @(negedge clk); while (!cell_stb_o);
    if (b && m_run >= 9) begin
      m_sync = 1; m_bc = 0;
    end else if (m_sync) begin
      m_sync = 0; m_sh = 8'h00; m_bc = 1;
    end else begin
      m_sh = {m_sh[6:0], b};
      if (m_bc == 7) begin exp_q.push_back(m_sh); m_bc = 0; end
      else m_bc++;
    end
    m_run = b ? ((m_run < 10) ? m_run + 1 : 10) : 0;
    @(negedge clk);
  endtask

  task automatic send_byte(logic [7:0] v);
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
  endtask

  task automatic ones(int n);
    for (int i = 0; i < n; i++) send_bit(1'b1);
  endtask

  task automatic host_acc(bit sel);
    acc_data_i = sel;
    acc_i = 1'b1;
    @(negedge clk);
    acc_i = 1'b0;
  endtask

  // scoreboard monitor
  logic prev_brdy = 1'b1;
  int wcnt = 0, last_w = 0, scnt = 0, last_p = 0, falls = 0;

  always @(negedge clk) begin
    if (rst_ni) begin
      if (prev_brdy && !brdy_n_o) begin
        falls++;
        if (exp_q.size() == 0) chk(0, "R5 R9 unexpected byte", byte_o, -1);
        else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          chk(byte_o == e, "R3 R5 byte value", byte_o, e);
        end
        wcnt = 1;
      end else if (!brdy_n_o) wcnt++;
      else if (!prev_brdy) last_w = wcnt;
      prev_brdy = brdy_n_o;
      if (cell_stb_o) begin last_p = scnt; scnt = 1; end
      else scnt++;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int f0;
    repeat (3) @(negedge clk);
    chk(sync_n_o == 1'b1, "R10 sync_n", sync_n_o, 1);
    chk(brdy_n_o == 1'b1, "R10 brdy_n", brdy_n_o, 1);
    chk(byte_o == 8'h00, "R10 byte", byte_o, 0);
    rst_ni = 1'b1;

    // R1: eight ones give a 0xFF byte, sync only after the tenth
    ones(9);
    chk(sync_n_o == 1'b1, "R1 nine ones", sync_n_o, 1);
    send_bit(1'b1);
    chk(sync_n_o == 1'b0, "R1 tenth one", sync_n_o, 0);
    ones(5);
    chk(sync_n_o == 1'b0, "R2 held through ones", sync_n_o, 0);
    send_bit(1'b0);
    chk(sync_n_o == 1'b1, "R2 released on zero", sync_n_o, 1);
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
    send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);   // R3: byte 0x52
    send_byte(8'hA7);
    send_byte(8'h3C);
    ones(1);
    chk(last_w == 32, "R6 zone0 pulse", last_w, 32);
    chk(last_p == 64, "R4 zone0 cell", last_p, 64);

    // R1 with trailing data ones
    send_byte(8'h07);
    ones(6);
    chk(sync_n_o == 1'b1, "R1 run of nine", sync_n_o, 1);
    send_bit(1'b1);
    chk(sync_n_o == 1'b0, "R1 trailing ones count", sync_n_o, 0);
    f0 = falls;
    ones(20);
    chk(falls == f0, "R9 no ready in sync", falls, f0);
    send_byte(8'h5A);

    for (int z = 1; z < 4; z++) begin
      zone_i = z[1:0];
      send_byte(8'h4B);
      send_byte(8'h2E);
      ones(2);
      chk(last_p == 4 * (16 - z), "R4 cell period", last_p, 4 * (16 - z));
      chk(last_w == 2 * (16 - z), "R6 pulse width", last_w, 2 * (16 - z));
      ones(14);
    end

    // handshake mode, zone 3
    hs_mode_i = 1'b1;
    send_byte(8'h67);
    ones(12);
    chk(brdy_n_o == 1'b0, "R7 held low", brdy_n_o, 0);
    host_acc(1'b0);
    chk(brdy_n_o == 1'b1, "R8 other access release", brdy_n_o, 1);
    chk(byte_o == 8'h67, "R8 other access keeps latch", byte_o, 8'h67);
    send_byte(8'h57);
    ones(12);
    chk(brdy_n_o == 1'b0, "R7 held low again", brdy_n_o, 0);
    host_acc(1'b1);
    chk(brdy_n_o == 1'b1, "R8 data access release", brdy_n_o, 1);
    chk(byte_o == 8'h00, "R8 data access clears", byte_o, 0);

    ones(2);
    chk(exp_q.size() == 0, "R5 all bytes delivered", exp_q.size(), 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule